// File: doc/BRIEF.md
# DMA Source-ID Rule Classifier

This block sits beside an I/O bridge and assigns every inbound DMA request to a supervisor domain. The bridge presents the request's 24-bit source identifier, a flag telling whether that identifier is a plain device ID or an IDE stream number combined with a segment number, and the request's TEE association bit. The block compares the request against a table of programmable rules in one combinational pass. One clock later it returns the winning rule's supervisor-domain ID, the IOMMU instance that should translate the request, the protection-table mode and the root page number of that table. When no rule accepts the request, it raises a miss flag instead.

Each rule selects one of three ways to compare source IDs: exact equality, a naturally aligned power-of-two block, or an interval bounded below by the previous rule's identifier. Each rule also filters on identifier kind and on TEE association. Rules are loaded one at a time through a per-index write port. When several rules accept a request, the lowest-numbered rule wins. The table walk that follows classification is not part of this block.

Top module: `dma_src_classifier`

## Requirements
- R1: After reset every rule holds identifier type 0, so every request gets a response with rsp_hit = 0.
- R2: A rule of identifier type 1 only accepts requests with req_is_ide = 0 (device ID). A rule of type 2 only accepts requests with req_is_ide = 1 (IDE stream in bits 7:0, segment in the bits above). Types 0 and 3 to 15 accept nothing.
- R3: Compare mode 1 (exact) accepts a request only when all 24 bits of the request ID equal the rule's stored ID.
- R4: Compare mode 2 (power-of-two block): if the stored ID has t trailing one bits, the low t+1 bits are ignored and the remaining bits must be equal. A stored ID of all ones accepts every ID.
- R5: Compare mode 3 (interval) accepts an ID that is at least the previous rule's stored ID and below this rule's stored ID. Rule 0 uses 0 as its lower bound.
- R6: Compare mode 0 accepts nothing.
- R7: TEE filter 1 accepts only req_tee = 1, filter 2 accepts only req_tee = 0, filter 3 accepts both, and filter 0 accepts nothing.
- R8: When several rules accept a request, the response carries the fields of the lowest-numbered accepting rule.
- R9: rsp_valid is high exactly in the cycle after each cycle with req_valid high. On a miss, rsp_hit = 0 and all response fields are zero.
- R10: A rule write takes effect at the clock edge that samples it. A request in the same cycle is classified against the previous table contents. The write changes no other rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | IDX_W | Index of the rule to write |
| cfg_id_type | input | 4 | Identifier type of the rule |
| cfg_match_mode | input | 2 | Source-ID compare mode |
| cfg_tee_filter | input | 2 | TEE association filter |
| cfg_src_id | input | 24 | Stored source ID |
| cfg_iommu_id | input | 8 | IOMMU instance for matching requests |
| cfg_sdid | input | 8 | Supervisor-domain ID |
| cfg_mpt_mode | input | 4 | Protection-table mode |
| cfg_root_ppn | input | 44 | Root page number of the protection table |
| req_valid | input | 1 | Request present this cycle |
| req_is_ide | input | 1 | 1: ID is IDE stream plus segment; 0: device ID |
| req_tee | input | 1 | Request is TEE associated |
| req_src_id | input | 24 | Request source ID |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A rule accepted the request |
| rsp_iommu_id | output | 8 | IOMMU instance of the winning rule |
| rsp_sdid | output | 8 | Supervisor-domain ID of the winning rule |
| rsp_mpt_mode | output | 4 | Table mode of the winning rule |
| rsp_root_ppn | output | 44 | Root page number of the winning rule |

## Verification
A rule write and a lookup can happen in the same cycle, and possibly to the very rule the lookup needs. The bench provokes this by writing a rule that makes a pending request hit and presenting that request on the same clock edge. It expects a miss for that request and a hit for an identical request one cycle later. Lookups that several rules accept at once are checked to return the lowest-numbered rule.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  parameter int SRC_W   = 24;
  parameter int IOMMU_W = 8;
  parameter int SDID_W  = 8;
  parameter int MODE_W  = 4;
  parameter int PPN_W   = 44;
  parameter int TYPE_W  = 4;

  typedef enum logic [1:0] {
    CMP_OFF   = 2'd0,
    CMP_EXACT = 2'd1,
    CMP_POW2  = 2'd2,
    CMP_RANGE = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic [TYPE_W-1:0]  id_type;
    logic [1:0]         match_mode;
    logic [1:0]         tee_filter;
    logic [SRC_W-1:0]   src_id;
    logic [IOMMU_W-1:0] iommu_id;
    logic [SDID_W-1:0]  sdid;
    logic [MODE_W-1:0]  mpt_mode;
    logic [PPN_W-1:0]   root_ppn;
  } dsc_rule_t;

  // Bits ignored in power-of-two mode: trailing ones plus the first zero.
  function automatic logic [SRC_W-1:0] pow2_ignore(input logic [SRC_W-1:0] id);
    return id ^ (id + SRC_W'(1));
  endfunction

  function automatic logic kind_ok(input logic [TYPE_W-1:0] t, input logic is_ide);
    return ((t == TYPE_W'(1)) && !is_ide) || ((t == TYPE_W'(2)) && is_ide);
  endfunction

  function automatic logic tee_ok(input logic [1:0] f, input logic tee);
    return (f == 2'd3) || ((f == 2'd1) && tee) || ((f == 2'd2) && !tee);
  endfunction
endpackage

// File: rtl/dsc_rule_table.sv
module dsc_rule_table
  import dsc_pkg::*;
#(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  dsc_rule_t                   wr_rule,
  output dsc_rule_t [NUM_RULES-1:0]   rules_o
);
  for (genvar i = 0; i < NUM_RULES; i++) begin : g_slot
    logic sel_here;
    assign sel_here = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)        rules_o[i] <= '0;
      else if (sel_here) rules_o[i] <= wr_rule;
    end

    // R10
    slot_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (rules_o[i] == $past(wr_rule)));
    // R10
    slot_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(rules_o[i]));
  end
endmodule

// File: rtl/dsc_rule_match.sv
module dsc_rule_match
  import dsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dsc_rule_t        rule_i,
  input  logic [SRC_W-1:0] lower_i,
  input  logic             req_is_ide,
  input  logic             req_tee,
  input  logic [SRC_W-1:0] req_id,
  output logic             hit_o
);
  logic             id_hit;
  logic [SRC_W-1:0] ignore_bits;
  logic             gate_ok;

  assign ignore_bits = pow2_ignore(rule_i.src_id);
  assign gate_ok     = kind_ok(rule_i.id_type, req_is_ide) && tee_ok(rule_i.tee_filter, req_tee);

  always_comb begin
    unique case (cmp_mode_e'(rule_i.match_mode))
      CMP_EXACT: id_hit = (req_id == rule_i.src_id);
      CMP_POW2:  id_hit = (((req_id ^ rule_i.src_id) & ~ignore_bits) == '0);
      CMP_RANGE: id_hit = (req_id >= lower_i) && (req_id < rule_i.src_id);
      default:   id_hit = 1'b0;
    endcase
  end

  assign hit_o = gate_ok && id_hit;

  // R6
  mode_off_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_i.match_mode == 2'd0) |-> !hit_o);
  // R2
  bad_type_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rule_i.id_type inside {4'd1, 4'd2}) |-> !hit_o);
  // R7
  tee_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_i.tee_filter == 2'd1 && !req_tee) |-> !hit_o);
  // R7
  tee_filter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_i.tee_filter == 2'd0) |-> !hit_o);
endmodule

// File: rtl/dsc_prio_pick.sv
module dsc_prio_pick #(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RULES-1:0] match_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match_i[i]) sel_o = IDX_W'(i);
    end
  end
  assign any_o = |match_i;

  logic [NUM_RULES-1:0] below_sel;
  assign below_sel = (NUM_RULES'(1) << sel_o) - NUM_RULES'(1);

  // R8
  pick_is_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> match_i[sel_o]);
  // R8
  pick_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((match_i & below_sel) == '0));
endmodule

// File: rtl/dma_src_classifier.sv
module dma_src_classifier
  import dsc_pkg::*;
#(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [TYPE_W-1:0]  cfg_id_type,
  input  logic [1:0]         cfg_match_mode,
  input  logic [1:0]         cfg_tee_filter,
  input  logic [SRC_W-1:0]   cfg_src_id,
  input  logic [IOMMU_W-1:0] cfg_iommu_id,
  input  logic [SDID_W-1:0]  cfg_sdid,
  input  logic [MODE_W-1:0]  cfg_mpt_mode,
  input  logic [PPN_W-1:0]   cfg_root_ppn,
  input  logic               req_valid,
  input  logic               req_is_ide,
  input  logic               req_tee,
  input  logic [SRC_W-1:0]   req_src_id,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IOMMU_W-1:0] rsp_iommu_id,
  output logic [SDID_W-1:0]  rsp_sdid,
  output logic [MODE_W-1:0]  rsp_mpt_mode,
  output logic [PPN_W-1:0]   rsp_root_ppn
);
  dsc_rule_t                 wr_rule;
  dsc_rule_t [NUM_RULES-1:0] rules;
  logic      [NUM_RULES-1:0] rule_hit;
  logic                      lookup_hit;
  logic      [IDX_W-1:0]     lookup_sel;
  dsc_rule_t                 winner;

  assign wr_rule = '{id_type: cfg_id_type, match_mode: cfg_match_mode,
                     tee_filter: cfg_tee_filter, src_id: cfg_src_id,
                     iommu_id: cfg_iommu_id, sdid: cfg_sdid,
                     mpt_mode: cfg_mpt_mode, root_ppn: cfg_root_ppn};

  dsc_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_rule(wr_rule), .rules_o(rules)
  );

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
    logic [SRC_W-1:0] lower;
    if (i == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = rules[i-1].src_id;
    end
    dsc_rule_match u_match (
      .clk(clk), .rst_n(rst_n), .rule_i(rules[i]), .lower_i(lower),
      .req_is_ide(req_is_ide), .req_tee(req_tee), .req_id(req_src_id),
      .hit_o(rule_hit[i])
    );
  end

  dsc_prio_pick #(.NUM_RULES(NUM_RULES)) u_pick (
    .clk(clk), .rst_n(rst_n), .match_i(rule_hit),
    .any_o(lookup_hit), .sel_o(lookup_sel)
  );

  assign winner = rules[lookup_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_iommu_id <= '0;
      rsp_sdid     <= '0;
      rsp_mpt_mode <= '0;
      rsp_root_ppn <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= lookup_hit;
        rsp_iommu_id <= lookup_hit ? winner.iommu_id : '0;
        rsp_sdid     <= lookup_hit ? winner.sdid     : '0;
        rsp_mpt_mode <= lookup_hit ? winner.mpt_mode : '0;
        rsp_root_ppn <= lookup_hit ? winner.root_ppn : '0;
      end
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_sdid == '0 && rsp_iommu_id == '0 &&
                                 rsp_mpt_mode == '0 && rsp_root_ppn == '0));
endmodule

// File: tb/dma_src_classifier_tb.sv
module dma_src_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_id_type;
  logic [1:0]  cfg_match_mode;
  logic [1:0]  cfg_tee_filter;
  logic [23:0] cfg_src_id;
  logic [7:0]  cfg_iommu_id;
  logic [7:0]  cfg_sdid;
  logic [3:0]  cfg_mpt_mode;
  logic [43:0] cfg_root_ppn;
  logic        req_valid;
  logic        req_is_ide;
  logic        req_tee;
  logic [23:0] req_src_id;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [7:0]  rsp_iommu_id;
  logic [7:0]  rsp_sdid;
  logic [3:0]  rsp_mpt_mode;
  logic [43:0] rsp_root_ppn;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_src_classifier #(.NUM_RULES(8)) u_dut (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_rule(input int idx, input logic [3:0] ty, input logic [1:0] md,
                          input logic [1:0] tf, input logic [23:0] sid,
                          input logic [7:0] sd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_id_type = ty; cfg_match_mode = md;
    cfg_tee_filter = tf; cfg_src_id = sid; cfg_sdid = sd;
    cfg_iommu_id = sd + 8'd1; cfg_mpt_mode = 4'(idx + 1);
    cfg_root_ppn = 44'h100_0000_0000 | 44'(sd);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Lookup: drive at negedge, response registered at next posedge, sample at following negedge.
  task automatic look(input string tag, input logic ide, input logic tee,
                      input logic [23:0] id, input logic exp_hit, input logic [7:0] exp_sd);
    @(negedge clk);
    req_valid = 1'b1; req_is_ide = ide; req_tee = tee; req_src_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " hit"}, rsp_hit, exp_hit);
    check({tag, " sdid"}, rsp_sdid, exp_hit ? exp_sd : 8'd0);
    check({tag, " ppn"}, rsp_root_ppn, exp_hit ? (44'h100_0000_0000 | 44'(exp_sd)) : 44'd0);
  endtask

  task automatic t_reset();
    check("R9 rsp_valid idle after reset", rsp_valid, 0);
    look("R1 empty table", 1'b0, 1'b0, 24'h001234, 1'b0, 8'd0);
    look("R1 empty table ide", 1'b1, 1'b1, 24'h000000, 1'b0, 8'd0);
    @(negedge clk);
    check("R9 rsp_valid drops", rsp_valid, 0);
  endtask

  task automatic t_exact();
    put_rule(0, 4'd1, 2'd1, 2'd3, 24'h001234, 8'd5);
    look("R3 exact hit", 1'b0, 1'b0, 24'h001234, 1'b1, 8'd5);
    check("R8 iommu field", rsp_iommu_id, 8'd6);
    check("R8 mode field", rsp_mpt_mode, 4'd1);
    look("R3 exact off by one", 1'b0, 1'b0, 24'h001235, 1'b0, 8'd0);
    look("R2 type1 rejects ide", 1'b1, 1'b0, 24'h001234, 1'b0, 8'd0);
  endtask

  task automatic t_pow2();
    put_rule(1, 4'd1, 2'd2, 2'd3, 24'h000507, 8'd7);
    look("R4 block top", 1'b0, 1'b1, 24'h00050F, 1'b1, 8'd7);
    look("R4 block base", 1'b0, 1'b0, 24'h000500, 1'b1, 8'd7);
    look("R4 above block", 1'b0, 1'b0, 24'h000510, 1'b0, 8'd0);
    look("R4 below block", 1'b0, 1'b0, 24'h0004FF, 1'b0, 8'd0);
  endtask

  task automatic t_range();
    put_rule(2, 4'd2, 2'd3, 2'd3, 24'h000800, 8'd9);
    look("R5 lower bound inclusive", 1'b1, 1'b0, 24'h000507, 1'b1, 8'd9);
    look("R5 last in range", 1'b1, 1'b0, 24'h0007FF, 1'b1, 8'd9);
    look("R5 upper exclusive", 1'b1, 1'b0, 24'h000800, 1'b0, 8'd0);
    look("R5 below lower", 1'b1, 1'b0, 24'h000506, 1'b0, 8'd0);
    look("R2 type2 rejects device", 1'b0, 1'b0, 24'h000600, 1'b0, 8'd0);
  endtask

  task automatic t_tee();
    put_rule(3, 4'd1, 2'd1, 2'd1, 24'h0A0000, 8'd11);
    put_rule(4, 4'd1, 2'd1, 2'd2, 24'h0B0000, 8'd12);
    put_rule(5, 4'd1, 2'd1, 2'd0, 24'h0C0000, 8'd13);
    look("R7 tee-only accepts tee", 1'b0, 1'b1, 24'h0A0000, 1'b1, 8'd11);
    look("R7 tee-only rejects non-tee", 1'b0, 1'b0, 24'h0A0000, 1'b0, 8'd0);
    look("R7 non-tee accepts non-tee", 1'b0, 1'b0, 24'h0B0000, 1'b1, 8'd12);
    look("R7 non-tee rejects tee", 1'b0, 1'b1, 24'h0B0000, 1'b0, 8'd0);
    look("R7 filter 0 rejects tee", 1'b0, 1'b1, 24'h0C0000, 1'b0, 8'd0);
    look("R7 filter 0 rejects non-tee", 1'b0, 1'b0, 24'h0C0000, 1'b0, 8'd0);
  endtask

  task automatic t_disabled();
    put_rule(6, 4'd1, 2'd0, 2'd3, 24'h0D0000, 8'd14);
    put_rule(7, 4'd5, 2'd1, 2'd3, 24'h0E0000, 8'd15);
    look("R6 compare mode 0", 1'b0, 1'b0, 24'h0D0000, 1'b0, 8'd0);
    look("R2 type 5 never", 1'b0, 1'b0, 24'h0E0000, 1'b0, 8'd0);
  endtask

  task automatic t_priority();
    put_rule(6, 4'd1, 2'd2, 2'd3, 24'h00FFFF, 8'd20);
    look("R8 rule0 beats rule6", 1'b0, 1'b0, 24'h001234, 1'b1, 8'd5);
    look("R8 rule1 beats rule6", 1'b0, 1'b0, 24'h000505, 1'b1, 8'd7);
    look("R8 only rule6", 1'b0, 1'b0, 24'h001300, 1'b1, 8'd20);
    put_rule(0, 4'd1, 2'd3, 2'd3, 24'h000010, 8'd30);
    look("R5 rule0 lower bound zero", 1'b0, 1'b0, 24'h000000, 1'b1, 8'd30);
    look("R5 rule0 last", 1'b0, 1'b0, 24'h00000F, 1'b1, 8'd30);
    look("R8 falls to rule6", 1'b0, 1'b0, 24'h000010, 1'b1, 8'd20);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd7; cfg_id_type = 4'd1; cfg_match_mode = 2'd1;
    cfg_tee_filter = 2'd3; cfg_src_id = 24'h0E0000; cfg_sdid = 8'd40;
    cfg_iommu_id = 8'd41; cfg_mpt_mode = 4'd8; cfg_root_ppn = 44'h100_0000_0000 | 44'd40;
    req_valid = 1'b1; req_is_ide = 1'b0; req_tee = 1'b0; req_src_id = 24'h0E0000;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 same-cycle sees old table", rsp_hit, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next cycle sees new rule", rsp_hit, 1);
    check("R10 next cycle sdid", rsp_sdid, 8'd40);
    look("R10 other rule unchanged", 1'b0, 1'b1, 24'h0A0000, 1'b1, 8'd11);
  endtask

  task automatic t_all_ones();
    put_rule(5, 4'd1, 2'd2, 2'd3, 24'hFFFFFF, 8'd50);
    look("R4 all ones accepts any", 1'b0, 1'b1, 24'hABCDEF, 1'b1, 8'd50);
    look("R4 all ones ide blocked by type", 1'b1, 1'b1, 24'hABCDEF, 1'b0, 8'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_id_type = '0; cfg_match_mode = '0;
    cfg_tee_filter = '0; cfg_src_id = '0; cfg_iommu_id = '0; cfg_sdid = '0;
    cfg_mpt_mode = '0; cfg_root_ppn = '0; req_valid = 1'b0; req_is_ide = 1'b0;
    req_tee = 1'b0; req_src_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_pow2();
    t_range();
    t_tee();
    t_disabled();
    t_priority();
    t_same_cycle();
    t_all_ones();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule